// File: doc/BRIEF.md
# Address-Match Breakpoint Controller

This block is the hardware breakpoint unit beside a small 8-bit CPU with a 16-bit address bus. Software loads a 16-bit compare address as two bytes and turns on an enable bit. The unit then watches every valid CPU bus cycle. When the CPU address equals the stored value, the unit takes a break at the next instruction boundary. It pulses a one-cycle request to the CPU and raises a break-active flag. That flag drives a freeze output that stops peripheral counters, such as a timer.

The unit also holds a software-break status bit and a clear-enable bit. While a break is active, the clear-enable bit decides whether status flags may be cleared, and the unit passes that permission to other blocks on a separate output. It also tells the CPU where to fetch the break vector. The vector address depends on whether monitor mode is selected. All registers sit on a byte-wide register bus based at $FE00. The CPU core, the timer, the watchdog and the monitor logic are outside the block.

Top module: `brk_unit`

## Requirements
- R1: After reset, all registers read 0 and brk_req_o and freeze_o are 0. flag_clr_en_o is 1, and vec_addr_o is $FFFC when monitor_i is 0.
- R2: The compare address high byte (bits 15..8) is read and written at $FE0C, and the low byte (bits 7..0) at $FE0D. Both are 8-bit read/write.
- R3: In the control register at $FE0E, bit 7 is the enable and is read/write. Bit 6 reads the break-active flag: writing 0 to it clears the flag, and writing 1 to it has no effect. Bits 5..0 read 0.
- R4: A match needs three things in the same cycle: the enable bit is 1, cpu_valid_i is 1, and cpu_addr_i equals the stored 16-bit value. Without any one of them there is no match.
- R5: If a match occurs in a cycle where instr_last_i is 1, brk_req_o is 1 for exactly the next cycle, and the active flag is set in that same cycle.
- R6: If a match occurs while instr_last_i is 0, the match is held pending. The request and the active flag follow in the cycle after the next cycle in which instr_last_i is 1, even if the address has changed by then.
- R7: freeze_o follows the active flag. After a write of 0 to bit 6 at $FE0E, freeze_o is 0 in the following cycle.
- R8: vec_addr_o gives the vector high-byte address: $FFFC when monitor_i is 0 and $FEFC when monitor_i is 1. The low byte is the next address.
- R9: Bit 1 of $FE00 is the software-break status. sw_break_i sets it. Writing 0 to it clears it, and writing 1 to it has no effect. If a set and a clear come in the same cycle, the set wins.
- R10: Bit 7 of $FE03 is the clear-enable bit, read/write, reset 0. While the active flag is 1 and this bit is 0, a write of 0 does not clear the status bit, and flag_clr_en_o is 0. In every other case flag_clr_en_o is 1.
- R11: Unmapped offsets and unimplemented bits read 0, and writes to them are ignored. reg_rdata_o is 0 when reg_sel_i is 0.
- R12: While the active flag is 1, matches are ignored: they raise no request and leave nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Register bus access strobe |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 16 | Register bus address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational |
| cpu_addr_i | input | 16 | CPU address bus |
| cpu_valid_i | input | 1 | CPU bus cycle valid |
| instr_last_i | input | 1 | Last cycle of the current instruction |
| monitor_i | input | 1 | Monitor mode select |
| sw_break_i | input | 1 | Software break event, sets the status bit |
| brk_req_o | output | 1 | One-cycle break request to the CPU |
| freeze_o | output | 1 | Freeze for peripheral counters |
| flag_clr_en_o | output | 1 | Permission to clear status flags |
| vec_addr_o | output | 16 | Break vector high-byte address |

## Verification
The match path is driven with address hits in four settings: with instr_last_i high, with instr_last_i low followed by a later boundary, with the enable off, and with cpu_valid_i low. A near-miss address is also used, so that hold-off and immediate entry can be told apart from false hits. Further hits are applied while a break is active, to separate ignoring a match from queueing it. The status bit is cleared with the clear-enable bit both off and on, during a break and outside one. Writes to unmapped offsets and reserved bits show whether any state leaks through.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int unsigned OFF_STAT    = 'h0;
  localparam int unsigned OFF_FLAGCTL = 'h3;
  localparam int unsigned OFF_ADDR_LO = 'hD;
  localparam int unsigned OFF_CTRL    = 'hE;
  localparam int unsigned BIT_SBRK    = 1;
  localparam int unsigned BIT_CLR_EN  = 7;
  localparam int unsigned BIT_EN      = 7;
  localparam int unsigned BIT_ACT     = 6;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REG_BASE = 'hFE00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              active_i,
  input  logic              sw_break_i,
  output logic [ADDR_W-1:0] brk_addr_o,
  output logic              brk_en_o,
  output logic              clr_en_o,
  output logic              act_clr_o
);
  localparam int unsigned NBYTES = ADDR_W / DATA_W;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_BASE + OFF_STAT);
  localparam logic [ADDR_W-1:0] A_FCTL = ADDR_W'(REG_BASE + OFF_FLAGCTL);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_BASE + OFF_CTRL);

  logic              wr_hit;
  logic              sbrk_q, en_q, clr_en_q;
  logic [DATA_W-1:0] byte_q [NBYTES];

  assign wr_hit = sel_i & wr_i;

  // compare address, low byte at the highest offset
  for (genvar i = 0; i < NBYTES; i++) begin : g_abyte
    localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(REG_BASE + OFF_ADDR_LO - i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          byte_q[i] <= '0;
      else if (wr_hit && addr_i == A_BYTE)  byte_q[i] <= wdata_i;
    end
    assign brk_addr_o[i*DATA_W +: DATA_W] = byte_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      clr_en_q <= 1'b0;
      sbrk_q   <= 1'b0;
    end else begin
      if (wr_hit && addr_i == A_CTRL) en_q     <= wdata_i[BIT_EN];
      if (wr_hit && addr_i == A_FCTL) clr_en_q <= wdata_i[BIT_CLR_EN];
      if (sw_break_i)
        sbrk_q <= 1'b1;
      else if (wr_hit && addr_i == A_STAT && !wdata_i[BIT_SBRK] && (!active_i || clr_en_q))
        sbrk_q <= 1'b0;
    end
  end

  assign act_clr_o = wr_hit && addr_i == A_CTRL && !wdata_i[BIT_ACT];
  assign brk_en_o  = en_q;
  assign clr_en_o  = clr_en_q;

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      if (addr_i == A_STAT) rdata_o[BIT_SBRK]   = sbrk_q;
      if (addr_i == A_FCTL) rdata_o[BIT_CLR_EN] = clr_en_q;
      if (addr_i == A_CTRL) begin
        rdata_o[BIT_EN]  = en_q;
        rdata_o[BIT_ACT] = active_i;
      end
      for (int i = 0; i < int'(NBYTES); i++)
        if (addr_i == ADDR_W'(REG_BASE + OFF_ADDR_LO - i)) rdata_o = byte_q[i];
    end
  end
endmodule

// File: rtl/brk_trigger.sv
module brk_trigger #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_valid_i,
  input  logic              instr_last_i,
  input  logic [ADDR_W-1:0] brk_addr_i,
  input  logic              brk_en_i,
  input  logic              act_clr_i,
  output logic              req_o,
  output logic              active_o
);
  logic hit, fire;
  logic pend_q, req_q, act_q;

  // no new hits while a break is in progress
  assign hit  = brk_en_i && cpu_valid_i && (cpu_addr_i == brk_addr_i) && !act_q;
  assign fire = (hit || pend_q) && instr_last_i && !act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      req_q <= fire;
      if (fire)     pend_q <= 1'b0;
      else if (hit) pend_q <= 1'b1;
      if (fire)           act_q <= 1'b1;
      else if (act_clr_i) act_q <= 1'b0;
    end
  end

  assign req_o    = req_q;
  assign active_o = act_q;
endmodule

// File: rtl/brk_vector.sv
module brk_vector #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned VEC_NORM = 'hFFFC,
  parameter int unsigned VEC_MON  = 'hFEFC
) (
  input  logic              monitor_i,
  output logic [ADDR_W-1:0] vec_o
);
  localparam logic [ADDR_W-1:0] V_N = ADDR_W'(VEC_NORM);
  localparam logic [ADDR_W-1:0] V_M = ADDR_W'(VEC_MON);
  assign vec_o = monitor_i ? V_M : V_N;
endmodule

// File: rtl/brk_unit.sv
module brk_unit #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REG_BASE = 'hFE00,
  parameter int unsigned VEC_NORM = 'hFFFC,
  parameter int unsigned VEC_MON  = 'hFEFC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_valid_i,
  input  logic              instr_last_i,
  input  logic              monitor_i,
  input  logic              sw_break_i,
  output logic              brk_req_o,
  output logic              freeze_o,
  output logic              flag_clr_en_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  logic [ADDR_W-1:0] brk_addr;
  logic              brk_en, clr_en, act_clr, active;

  brk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_BASE(REG_BASE)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (reg_sel_i),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .active_i   (active),
    .sw_break_i (sw_break_i),
    .brk_addr_o (brk_addr),
    .brk_en_o   (brk_en),
    .clr_en_o   (clr_en),
    .act_clr_o  (act_clr)
  );

  brk_trigger #(.ADDR_W(ADDR_W)) trig_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_valid_i  (cpu_valid_i),
    .instr_last_i (instr_last_i),
    .brk_addr_i   (brk_addr),
    .brk_en_i     (brk_en),
    .act_clr_i    (act_clr),
    .req_o        (brk_req_o),
    .active_o     (active)
  );

  brk_vector #(.ADDR_W(ADDR_W), .VEC_NORM(VEC_NORM), .VEC_MON(VEC_MON)) vec_i (
    .monitor_i (monitor_i),
    .vec_o     (vec_addr_o)
  );

  assign freeze_o      = active;
  assign flag_clr_en_o = !active || clr_en;
endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REG_BASE = 'hFE00
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_sel_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              instr_last_i,
  input logic              brk_req_o,
  input logic              freeze_o,
  input logic              flag_clr_en_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_BASE + 'hE);

  p_req_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |=> !brk_req_o);
  p_req_with_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> freeze_o);
  p_freeze_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(freeze_o) |-> brk_req_o);
  p_req_at_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> $past(instr_last_i));
  p_freeze_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(freeze_o) |-> $past(reg_sel_i && reg_wr_i && reg_addr_i == A_CTRL && !reg_wdata_i[6]));
  p_clr_perm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_clr_en_o |-> freeze_o);
  p_idle_rdata_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> reg_rdata_o == '0);
  p_no_rereq_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> !$past(freeze_o));
endmodule

bind brk_unit brk_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_BASE(REG_BASE)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_sel_i     (reg_sel_i),
  .reg_wr_i      (reg_wr_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .instr_last_i  (instr_last_i),
  .brk_req_o     (brk_req_o),
  .freeze_o      (freeze_o),
  .flag_clr_en_o (flag_clr_en_o)
);

// File: tb/brk_unit_tb_top.sv
module brk_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_sel_i = 1'b0, reg_wr_i = 1'b0;
  logic [15:0] reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [15:0] cpu_addr_i = '0;
  logic        cpu_valid_i = 1'b0, instr_last_i = 1'b0, monitor_i = 1'b0, sw_break_i = 1'b0;
  logic        brk_req_o, freeze_o, flag_clr_en_o;
  logic [15:0] vec_addr_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  brk_unit dut_i (.*);

  // reference model state
  bit       m_en, m_act, m_pend, m_req, m_sbrk, m_clr;
  bit [7:0] m_hi, m_lo;

  function automatic bit [7:0] m_read(input bit sel, input bit [15:0] a);
    bit [7:0] r = 0;
    if (!sel) return 0;
    case (a)
      16'hFE00: r[1] = m_sbrk;
      16'hFE03: r[7] = m_clr;
      16'hFE0C: r = m_hi;
      16'hFE0D: r = m_lo;
      16'hFE0E: begin r[7] = m_en; r[6] = m_act; end
      default:  r = 0;
    endcase
    return r;
  endfunction

  function automatic string rd_req(input bit [15:0] a);
    case (a)
      16'hFE00: return "R9";
      16'hFE03: return "R10";
      16'hFE0C, 16'hFE0D: return "R2";
      16'hFE0E: return "R3";
      default:  return "R11";
    endcase
  endfunction

  task automatic cmp(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk_i) begin
    bit wr, hit, fire, act_n, sbrk_n;
    cycles++;
    if (!rst_ni) begin
      {m_en, m_act, m_pend, m_req, m_sbrk, m_clr} = '0;
      m_hi = 0; m_lo = 0;
    end else begin
      wr   = reg_sel_i && reg_wr_i;
      hit  = m_en && cpu_valid_i && cpu_addr_i == {m_hi, m_lo} && !m_act;
      fire = (hit || m_pend) && instr_last_i && !m_act;
      act_n = fire ? 1'b1 : (wr && reg_addr_i == 16'hFE0E && !reg_wdata_i[6]) ? 1'b0 : m_act;
      sbrk_n = sw_break_i ? 1'b1 :
               (wr && reg_addr_i == 16'hFE00 && !reg_wdata_i[1] && (!m_act || m_clr)) ? 1'b0 : m_sbrk;
      m_pend = fire ? 1'b0 : (m_pend || hit);
      m_req  = fire;
      if (wr && reg_addr_i == 16'hFE0E) m_en  = reg_wdata_i[7];
      if (wr && reg_addr_i == 16'hFE03) m_clr = reg_wdata_i[7];
      if (wr && reg_addr_i == 16'hFE0C) m_hi  = reg_wdata_i;
      if (wr && reg_addr_i == 16'hFE0D) m_lo  = reg_wdata_i;
      m_act  = act_n;
      m_sbrk = sbrk_n;
    end
    #2;
    if (rst_ni && !done) begin
      cmp(m_req ? "R5/R6" : "R4/R12", "brk_req_o", brk_req_o, m_req);
      cmp("R7", "freeze_o", freeze_o, m_act);
      cmp("R10", "flag_clr_en_o", flag_clr_en_o, !m_act || m_clr);
      cmp("R8", "vec_addr_o", vec_addr_o, monitor_i ? 16'hFEFC : 16'hFFFC);
      cmp(rd_req(reg_addr_i), "reg_rdata_o", reg_rdata_o, m_read(reg_sel_i, reg_addr_i));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_reg(input bit [15:0] a, input bit [7:0] d);
    @(negedge clk_i);
    reg_sel_i = 1; reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_sel_i = 0; reg_wr_i = 0; reg_wdata_i = 0;
  endtask

  task automatic rd_reg(input bit [15:0] a);
    @(negedge clk_i);
    reg_sel_i = 1; reg_wr_i = 0; reg_addr_i = a;
    @(negedge clk_i);
    reg_sel_i = 0;
  endtask

  task automatic cpu(input bit [15:0] a, input bit v, input bit last);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_valid_i = v; instr_last_i = last;
    @(negedge clk_i);
    cpu_valid_i = 0; instr_last_i = 0; cpu_addr_i = 16'h0000;
  endtask

  task automatic dump_regs();
    rd_reg(16'hFE00); rd_reg(16'hFE03); rd_reg(16'hFE0C);
    rd_reg(16'hFE0D); rd_reg(16'hFE0E);
  endtask

  initial begin
    idle(3);
    @(negedge clk_i) rst_ni = 1;
    // R1 reset values
    dump_regs();
    // R2, R3, R11 register access
    wr_reg(16'hFE0C, 8'h12); wr_reg(16'hFE0D, 8'h34);
    wr_reg(16'hFE0E, 8'h3F);
    dump_regs();
    // R4 no match while disabled
    cpu(16'h1234, 1, 1); idle(2);
    wr_reg(16'hFE0E, 8'hFF);
    rd_reg(16'hFE0E);
    // R4 invalid cycle, near-miss address
    cpu(16'h1234, 0, 1); cpu(16'h1235, 1, 1); cpu(16'h0234, 1, 1); idle(2);
    // R5 match on last cycle
    cpu(16'h1234, 1, 1); idle(2); rd_reg(16'hFE0E);
    // R12 hits while active ignored
    cpu(16'h1234, 1, 0); cpu(16'h1234, 1, 1); idle(1);
    // R3 write 1 to bit 6 leaves flag set
    wr_reg(16'hFE0E, 8'hC0); rd_reg(16'hFE0E);
    // R7 clear
    wr_reg(16'hFE0E, 8'h80); idle(1); rd_reg(16'hFE0E);
    // nothing queued from the active window
    cpu(16'h4000, 1, 1); idle(2);
    // R6 mid-instruction match held until boundary
    cpu(16'h1234, 1, 0); cpu(16'h1300, 1, 0); idle(2); cpu(16'h5555, 1, 1); idle(2);
    // R8 monitor mode vector
    @(negedge clk_i) monitor_i = 1; idle(3);
    @(negedge clk_i) monitor_i = 0; idle(1);
    // R9 / R10 status clear with permission off during break
    @(negedge clk_i) sw_break_i = 1; @(negedge clk_i) sw_break_i = 0;
    rd_reg(16'hFE00);
    wr_reg(16'hFE00, 8'h00); rd_reg(16'hFE00);
    // R10 permission on
    wr_reg(16'hFE03, 8'hFF); rd_reg(16'hFE03);
    wr_reg(16'hFE00, 8'hFD); rd_reg(16'hFE00);
    wr_reg(16'hFE03, 8'h00);
    wr_reg(16'hFE0E, 8'h80);
    // R9 outside a break: write 1 no effect, write 0 clears, set wins
    @(negedge clk_i) sw_break_i = 1; @(negedge clk_i) sw_break_i = 0;
    wr_reg(16'hFE00, 8'hFF); rd_reg(16'hFE00);
    wr_reg(16'hFE00, 8'h00); rd_reg(16'hFE00);
    @(negedge clk_i);
    sw_break_i = 1; reg_sel_i = 1; reg_wr_i = 1; reg_addr_i = 16'hFE00; reg_wdata_i = 0;
    @(negedge clk_i);
    sw_break_i = 0; reg_sel_i = 0; reg_wr_i = 0;
    rd_reg(16'hFE00);
    // R11 unmapped writes ignored
    wr_reg(16'hFE01, 8'hFF); wr_reg(16'hFE0F, 8'hFF); wr_reg(16'h1234, 8'hFF);
    wr_reg(16'hFE0B, 8'hFF);
    rd_reg(16'hFE01); rd_reg(16'hFE0F); rd_reg(16'hFE0B);
    dump_regs();
    // disable, then match ignored
    wr_reg(16'hFE0E, 8'h00);
    cpu(16'h1234, 1, 1); idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule